// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block is a clocked address/command register for a memory module. On every rising clock edge it captures a word from the data lanes and drives it onto registered outputs. The data lanes are captured only when at least one of two active-low chip-select inputs is low. If both chip selects are high, the data outputs keep their previous word. Three control lanes are captured on every edge, whatever the chip selects are doing: the primary chip select, an on-die-termination enable and a clock enable.

The block has two lane configurations. In single mode, 25 lanes map one-to-one onto output copy A. In dual mode, the low 14 lanes are captured and driven identically onto copy A and copy B, so one register bank can feed two loads. The mode select is treated as static and is sampled only while reset is held. An asynchronous active-low reset forces every output low at once.

Top module: `cs_gated_cmd_reg`

## Requirements
- R1: While `rst_n` is low, `q_a`, `q_b`, `q_cs_n`, `q_odt` and `q_cke` are all zero. This takes effect immediately, without waiting for a clock edge.
- R2: With `rst_n` high and `cs0_n` low or `cs1_n` low, the captured data lanes take the value of `d` on the rising edge of `clk`.
- R3: With `rst_n` high and both `cs0_n` and `cs1_n` high, `q_a` and `q_b` keep their previous values across the rising edge.
- R4: On every rising edge with `rst_n` high, `q_cs_n` takes the value of `cs0_n`. `cs1_n` has no effect on it.
- R5: On every rising edge with `rst_n` high, `q_odt` takes `odt_i` and `q_cke` takes `cke_i`, whatever the chip selects are.
- R6: In dual mode (`mode_sel` = 1), `q_a[13:0]` and `q_b[13:0]` both carry the captured `d[13:0]`, and `q_a[24:14]` is zero.
- R7: In single mode (`mode_sel` = 0), `q_a[24:0]` carries all 25 captured lanes and `q_b` is zero.
- R8: `mode_sel` is sampled on rising edges while `rst_n` is low. A change of `mode_sel` while `rst_n` is high has no effect on the outputs.
- R9: Between rising edges, a change on any input other than `rst_n` leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock; all captures happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; all outputs are low while it is low |
| mode_sel | input | 1 | Lane configuration: 0 = 25 lanes one-to-one, 1 = 14 lanes duplicated |
| cs0_n | input | 1 | Primary active-low chip select; gates data capture and is forwarded to `q_cs_n` |
| cs1_n | input | 1 | Secondary active-low chip select; gates data capture only |
| d | input | 25 | Data lanes |
| odt_i | input | 1 | Termination-enable input |
| cke_i | input | 1 | Clock-enable input |
| q_a | output | 25 | Registered data, copy A |
| q_b | output | 14 | Registered data, copy B (dual mode only) |
| q_cs_n | output | 1 | Registered primary chip select |
| q_odt | output | 1 | Registered termination enable |
| q_cke | output | 1 | Registered clock enable |

## Verification
The data outputs and the three control outputs change one rising edge after the inputs that produce them. Reset clears the outputs at once, and the mode takes effect on the first edge that falls within reset. The bench changes inputs just after a falling edge. It first checks, a short time later and before the next rising edge, that the outputs have not moved. It then compares them, at the next falling edge, against a model that it advanced at the rising edge in between. An asynchronous reset pulse is checked within a nanosecond of assertion, away from any edge.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DUAL   = 1'b1
  } lane_mode_e;

  localparam int unsigned CTRL_LANES = 3;
  localparam int unsigned CTRL_CS    = 0;
  localparam int unsigned CTRL_ODT   = 1;
  localparam int unsigned CTRL_CKE   = 2;
endpackage

// File: rtl/cmdreg_mode_latch.sv
module cmdreg_mode_latch
  import cmdreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_sel_i,
  output lane_mode_e mode_o
);
  lane_mode_e mode_q;

  // Loaded only while reset is held; frozen otherwise.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= lane_mode_e'(mode_sel_i);
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/cmdreg_bank.sv
module cmdreg_bank #(
  parameter int unsigned W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (en_i) begin
      q_r <= d_i;
    end
  end

  assign q_o = q_r;
endmodule

// File: rtl/cmdreg_fanout.sv
module cmdreg_fanout
  import cmdreg_pkg::*;
#(
  parameter int unsigned WIDE_W   = 25,
  parameter int unsigned NARROW_W = 14
) (
  input  lane_mode_e          mode_i,
  input  logic [WIDE_W-1:0]   core_i,
  output logic [WIDE_W-1:0]   q_a_o,
  output logic [NARROW_W-1:0] q_b_o
);
  localparam int unsigned UPPER_W = WIDE_W - NARROW_W;

  logic dual;
  assign dual = (mode_i == MODE_DUAL);

  for (genvar i = 0; i < NARROW_W; i++) begin : g_pair
    assign q_a_o[i] = core_i[i];
    assign q_b_o[i] = dual & core_i[i];
  end

  for (genvar j = 0; j < UPPER_W; j++) begin : g_upper
    assign q_a_o[NARROW_W+j] = ~dual & core_i[NARROW_W+j];
  end
endmodule

// File: rtl/cs_gated_cmd_reg.sv
module cs_gated_cmd_reg
  import cmdreg_pkg::*;
#(
  parameter int unsigned WIDE_W   = 25,
  parameter int unsigned NARROW_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_sel,
  input  logic                cs0_n,
  input  logic                cs1_n,
  input  logic [WIDE_W-1:0]   d,
  input  logic                odt_i,
  input  logic                cke_i,
  output logic [WIDE_W-1:0]   q_a,
  output logic [NARROW_W-1:0] q_b,
  output logic                q_cs_n,
  output logic                q_odt,
  output logic                q_cke
);
  lane_mode_e              mode;
  logic                    data_en;
  logic [WIDE_W-1:0]       core_q;
  logic [CTRL_LANES-1:0]   ctrl_d;
  logic [CTRL_LANES-1:0]   ctrl_q;

  assign data_en = ~(cs0_n & cs1_n);

  always_comb begin
    ctrl_d           = '0;
    ctrl_d[CTRL_CS]  = cs0_n;
    ctrl_d[CTRL_ODT] = odt_i;
    ctrl_d[CTRL_CKE] = cke_i;
  end

  cmdreg_mode_latch u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel_i (mode_sel),
    .mode_o     (mode)
  );

  cmdreg_bank #(.W(WIDE_W)) u_data (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (data_en),
    .d_i   (d),
    .q_o   (core_q)
  );

  cmdreg_bank #(.W(CTRL_LANES)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (1'b1),
    .d_i   (ctrl_d),
    .q_o   (ctrl_q)
  );

  cmdreg_fanout #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_fan (
    .mode_i (mode),
    .core_i (core_q),
    .q_a_o  (q_a),
    .q_b_o  (q_b)
  );

  assign q_cs_n = ctrl_q[CTRL_CS];
  assign q_odt  = ctrl_q[CTRL_ODT];
  assign q_cke  = ctrl_q[CTRL_CKE];
endmodule

// File: rtl/cmdreg_checker.sv
module cmdreg_checker #(
  parameter int unsigned WIDE_W   = 25,
  parameter int unsigned NARROW_W = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dual,
  input logic                cs0_n,
  input logic                cs1_n,
  input logic [WIDE_W-1:0]   d,
  input logic                odt_i,
  input logic                cke_i,
  input logic [WIDE_W-1:0]   q_a,
  input logic [NARROW_W-1:0] q_b,
  input logic                q_cs_n,
  input logic                q_odt,
  input logic                q_cke
);
  // R1: outputs are clear while reset is held
  always @(negedge clk) begin
    if (rst_n == 1'b0) begin
      assert_reset_clear_R1: assert (q_a == '0 && q_b == '0 && !q_cs_n && !q_odt && !q_cke);
    end
  end

  // R2
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs0_n || !cs1_n) |=> (dual ? (q_b == $past(d[NARROW_W-1:0])) : (q_a == $past(d))));

  // R3
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs0_n && cs1_n) |=> ($stable(q_a) && $stable(q_b)));

  // R4
  assert_cs_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_cs_n == $past(cs0_n)));

  // R5
  assert_ctrl_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_odt == $past(odt_i) && q_cke == $past(cke_i)));

  // R6
  assert_dual_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dual |-> (q_b == q_a[NARROW_W-1:0] && q_a[WIDE_W-1:NARROW_W] == '0));

  // R7
  assert_single_b_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dual |-> (q_b == '0));

  // R8
  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(dual));
endmodule

bind cs_gated_cmd_reg cmdreg_checker #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .dual   (mode == cmdreg_pkg::MODE_DUAL),
  .cs0_n  (cs0_n),
  .cs1_n  (cs1_n),
  .d      (d),
  .odt_i  (odt_i),
  .cke_i  (cke_i),
  .q_a    (q_a),
  .q_b    (q_b),
  .q_cs_n (q_cs_n),
  .q_odt  (q_odt),
  .q_cke  (q_cke)
);

// File: tb/test_cs_gated_cmd_reg.sv
module test_cs_gated_cmd_reg;
  localparam int WW = 25;
  localparam int NW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          mode_sel = 1'b0;
  logic          cs0_n = 1'b1;
  logic          cs1_n = 1'b1;
  logic [WW-1:0] d = '0;
  logic          odt_i = 1'b0;
  logic          cke_i = 1'b0;
  logic [WW-1:0] q_a;
  logic [NW-1:0] q_b;
  logic          q_cs_n, q_odt, q_cke;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // model state
  logic [WW-1:0] m_core;
  logic          m_cs, m_odt, m_cke;
  bit            m_dual;

  always #4 clk = ~clk;

  cs_gated_cmd_reg #(.WIDE_W(WW), .NARROW_W(NW)) i_cs_gated_cmd_reg (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs0_n(cs0_n), .cs1_n(cs1_n),
    .d(d), .odt_i(odt_i), .cke_i(cke_i), .q_a(q_a), .q_b(q_b),
    .q_cs_n(q_cs_n), .q_odt(q_odt), .q_cke(q_cke)
  );

  function automatic logic [WW-1:0] exp_a();
    if (m_dual) return {{(WW-NW){1'b0}}, m_core[NW-1:0]};
    return m_core;
  endfunction

  function automatic logic [NW-1:0] exp_b();
    if (m_dual) return m_core[NW-1:0];
    return '0;
  endfunction

  task automatic chk(input string req, input string what, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string dreq);
    chk(dreq, "q_a", q_a, exp_a());
    chk(m_dual ? "R6" : "R7", "q_b", WW'(q_b), WW'(exp_b()));
    chk("R4", "q_cs_n", WW'(q_cs_n), WW'(m_cs));
    chk("R5", "q_odt", WW'(q_odt), WW'(m_odt));
    chk("R5", "q_cke", WW'(q_cke), WW'(m_cke));
  endtask

  // One cycle: drive after a falling edge, confirm no change, clock, compare.
  task automatic cycle(input logic [WW-1:0] dv, input logic c0, input logic c1,
                       input logic o, input logic k);
    string dreq;
    d = dv; cs0_n = c0; cs1_n = c1; odt_i = o; cke_i = k;
    #1;
    check_all("R9");
    @(posedge clk);
    if (!(c0 && c1)) m_core = dv;
    m_cs = c0; m_odt = o; m_cke = k;
    dreq = (c0 && c1) ? "R3" : (m_dual ? "R6" : "R2");
    @(negedge clk);
    check_all(dreq);
  endtask

  task automatic do_reset(input bit dual);
    @(negedge clk);
    #1 rst_n = 1'b0;
    mode_sel = dual;
    m_core = '0; m_cs = 1'b0; m_odt = 1'b0; m_cke = 1'b0;
    #1;
    check_all("R1");
    @(posedge clk);
    m_dual = dual;
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_dual = 1'b0;
    #1 rst_n = 1'b0;
    m_core = '0; m_cs = 1'b0; m_odt = 1'b0; m_cke = 1'b0;

    // single mode
    do_reset(1'b0);
    cycle(25'h1AB_CDEF, 1'b0, 1'b1, 1'b1, 1'b0); // R2 via cs0_n
    cycle(25'h0F0_F0F0, 1'b1, 1'b0, 1'b0, 1'b1); // R2 via cs1_n, R4 cs1 ignored
    cycle(25'h1FF_FFFF, 1'b1, 1'b1, 1'b1, 1'b1); // R3 hold, R5 still updates
    cycle(25'h000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    cycle(25'h1FF_FFFF, 1'b0, 1'b1, 1'b1, 1'b0); // R7 upper lanes carried
    // R8: mode change while running is ignored
    mode_sel = 1'b1;
    for (int i = 0; i < 200; i++) begin
      logic [WW-1:0] r;
      r = WW'($urandom);
      cycle(r, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // R1: asynchronous reset in the middle of a cycle, then dual mode
    do_reset(1'b1);
    cycle(25'h1FF_FFFF, 1'b0, 1'b1, 1'b1, 1'b1); // R6 upper A low
    cycle(25'h0AA_5555, 1'b1, 1'b1, 1'b0, 1'b0); // R3
    cycle(25'h155_2AAA, 1'b1, 1'b0, 1'b1, 1'b0);
    mode_sel = 1'b0; // R8
    for (int i = 0; i < 200; i++) begin
      logic [WW-1:0] r;
      r = WW'($urandom);
      cycle(r, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // back to single mode through reset
    do_reset(1'b0);
    cycle(25'h1C0_0001, 1'b0, 1'b0, 1'b1, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule